// File: doc/BRIEF.md
# Goldilocks In-Place Number-Theoretic Transform Engine

This block computes a forward or inverse number-theoretic transform over the prime field with modulus p = 2^64 − 2^32 + 1. The data sits in an internal word-addressed RAM of 64-bit field elements. A single command supplies the block's start address, the base-two logarithm L of the transform length N = 2^L, and a direction bit. The engine rewrites the N words in place and raises a one-cycle completion pulse. Between commands, a simple host port loads operands into the RAM and reads results back.

The engine uses radix-2 butterflies. Each butterfly scales its upper operand by a twiddle factor and writes back the sum and the difference. One butterfly completes every clock cycle, so a forward transform occupies N/2·L cycles. Twiddles come from a ROM of precomputed powers of a primitive root derived from the generator 7. The ROM holds the forward powers in one region and the inverse powers in another. An inverse transform adds a final pass that multiplies every word by N^−1 mod p. Input is read in natural order and results are left in bit-reversed order.

Top module: `gl_ntt_engine`

## Requirements
- R1: Forward transform, with cmd_inv = 0. Let x_j be the word at address base+j and ω = 7^((p−1)/N) mod p. After the command, address base+i holds X[k] = Σ_j x_j·ω^(j·k) mod p, where k is i with its L low bits reversed.
- R2: Inverse transform, with cmd_inv = 1. Address base+i holds N^−1·Σ_j x_j·ω^(−j·k) mod p, with k the L-bit reversal of i. A forward transform, a bit-reversal reorder, an inverse transform and a second reorder therefore return the original data.
- R3: Every length from N = 2 (cmd_log = 1) up to N = 2^MAX_LOG is supported. Block addresses are taken modulo the RAM depth 2^ADDR_W, so a block may wrap past the top address.
- R4: busy is high for exactly N/2·L cycles on a forward command and for N/2·L + N cycles on an inverse command. It rises on the clock edge that accepts the command.
- R5: done is high for exactly one cycle. That cycle is the first one in which busy is low again after a run.
- R6: A command presented while busy is high is ignored. It does not change the running transform, its timing, or any RAM word.
- R7: A command with cmd_log = 0 or cmd_log > MAX_LOG is ignored. busy stays low, done stays low and no RAM word changes.
- R8: A host write is ignored while busy is high. A host read returns mem[host_addr] one cycle after the address is presented.
- R9: A transform changes no RAM word outside its own N addresses.
- R10: After reset, busy and done are low.
- R11: Operands anywhere in [0, p−1] are handled, including the largest value p−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_base | input | ADDR_W | Start address of the block |
| cmd_log | input | LOGW | log2 of the transform length |
| cmd_inv | input | 1 | 0 forward, 1 inverse |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host RAM address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Registered host read data |

## Verification
The hardest situation to reach from the ports is a collision with a running transform: a second command or a host write that arrives while the butterflies are rewriting the RAM. The stimulus loads a block, starts the transform, and on the second busy cycle drives a competing command, a host write, or both. The competing command targets a different base address and the opposite direction. The host write targets a guard word just past the block. The bench then checks that the run length is unchanged, that every transformed word still matches a direct O(N²) evaluation, and that the guard words keep their values. Blocks that wrap past the top RAM address and all-(p−1) operands are covered by the same length sweep.

// File: rtl/gl_ntt_pkg.sv
package gl_ntt_pkg;

   localparam logic [63:0] GL_P   = 64'hFFFF_FFFF_0000_0001;
   localparam logic [63:0] GL_GEN = 64'd7;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_BFLY  = 2'd1,
      PH_SCALE = 2'd2
   } ntt_phase_e;

   // Field addition of two reduced operands.
   function automatic logic [63:0] gl_add(input logic [63:0] a, input logic [63:0] b);
      logic [64:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (s >= {1'b0, GL_P}) s = s - {1'b0, GL_P};
      return s[63:0];
   endfunction

   // Field subtraction of two reduced operands.
   function automatic logic [63:0] gl_sub(input logic [63:0] a, input logic [63:0] b);
      logic [63:0] d;
      if (a >= b) d = a - b;
      else        d = a + (GL_P - b);
      return d;
   endfunction

   // Wide-remainder product, used only to fill constant tables.
   function automatic logic [63:0] gl_mul_init(input logic [63:0] a, input logic [63:0] b);
      logic [127:0] prod;
      prod = {64'd0, a} * {64'd0, b};
      prod = prod % {64'd0, GL_P};
      return prod[63:0];
   endfunction

   function automatic logic [63:0] gl_pow_init(input logic [63:0] base, input logic [63:0] e);
      logic [63:0] r;
      logic [63:0] b;
      r = 64'd1;
      b = base;
      for (int i = 0; i < 64; i++) begin
         if (e[i]) r = gl_mul_init(r, b);
         b = gl_mul_init(b, b);
      end
      return r;
   endfunction

endpackage

// File: rtl/gl_mulmod.sv
module gl_mulmod
   import gl_ntt_pkg::*;
(
   input  logic [63:0] a,
   input  logic [63:0] b,
   output logic [63:0] y
);

   localparam logic [66:0] P1 = {3'd0, GL_P};
   localparam logic [66:0] P2 = P1 << 1;
   localparam logic [66:0] P3 = P1 + P2;

   logic [127:0] prod;
   logic [63:0]  lo;
   logic [31:0]  hl;
   logic [31:0]  hh;
   logic [66:0]  v;
   logic [66:0]  v1;
   logic [66:0]  v2;
   logic [66:0]  v3;

   // 2^64 = 2^32 - 1 and 2^96 = -1 (mod p): fold the high half sparsely.
   always_comb begin
      prod = {64'd0, a} * {64'd0, b};
      lo   = prod[63:0];
      hl   = prod[95:64];
      hh   = prod[127:96];
      v    = {3'd0, lo} + ({35'd0, hl} << 32) - {35'd0, hl} + P1 - {35'd0, hh};
      v1   = v - P1;
      v2   = v - P2;
      v3   = v - P3;
      if (v >= P3)      y = v3[63:0];
      else if (v >= P2) y = v2[63:0];
      else if (v >= P1) y = v1[63:0];
      else              y = v[63:0];
   end

endmodule

// File: rtl/gl_butterfly.sv
module gl_butterfly
   import gl_ntt_pkg::*;
(
   input  logic [63:0] a,
   input  logic [63:0] b,
   input  logic [63:0] w,
   output logic [63:0] prod,
   output logic [63:0] sum,
   output logic [63:0] diff
);

   gl_mulmod u_mul (
      .a (b),
      .b (w),
      .y (prod)
   );

   always_comb begin
      sum  = gl_add(a, prod);
      diff = gl_sub(a, prod);
   end

endmodule

// File: rtl/gl_twiddle_rom.sv
module gl_twiddle_rom
   import gl_ntt_pkg::*;
#(
   parameter int MAX_LOG = 8
) (
   input  logic               inv,
   input  logic [MAX_LOG-2:0] idx,
   output logic [63:0]        w
);

   localparam int IDXW  = MAX_LOG - 1;
   localparam int HALF  = 1 << IDXW;
   localparam int ENTRY = 2 * HALF;

   logic [63:0] tab [ENTRY];
   logic [63:0] root_f;
   logic [63:0] root_i;

   function automatic logic [63:0] rev_idx(input int unsigned v);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < IDXW; i++) begin
         if (v[i]) r[IDXW-1-i] = 1'b1;
      end
      return r;
   endfunction

   // Entry g holds root^rev(g); the same entry serves every length.
   initial begin
      root_f = gl_pow_init(GL_GEN, (GL_P - 64'd1) >> MAX_LOG);
      root_i = gl_pow_init(root_f, (64'd1 << MAX_LOG) - 64'd1);
      for (int g = 0; g < HALF; g++) begin
         tab[g]        = gl_pow_init(root_f, rev_idx(g));
         tab[HALF + g] = gl_pow_init(root_i, rev_idx(g));
      end
   end

   assign w = tab[{inv, idx}];

endmodule

// File: rtl/gl_ntt_seq.sv
module gl_ntt_seq
   import gl_ntt_pkg::*;
#(
   parameter int MAX_LOG = 8,
   parameter int LOGW    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LOGW-1:0]    log_n,
   input  logic               inv,
   output ntt_phase_e         phase,
   output logic               inv_q,
   output logic [MAX_LOG-1:0] lo_off,
   output logic [MAX_LOG-1:0] hi_off,
   output logic [MAX_LOG-2:0] tw_idx,
   output logic               done
);

   logic [LOGW-1:0]    len_log;
   logic [LOGW-1:0]    stage;
   logic [LOGW-1:0]    shift;
   logic [MAX_LOG-1:0] cnt;
   logic [MAX_LOG-1:0] span;
   logic [MAX_LOG-1:0] grp;
   logic [MAX_LOG-1:0] half_m1;
   logic [MAX_LOG-1:0] full_m1;

   always_comb begin
      shift   = len_log - stage - LOGW'(1);
      span    = MAX_LOG'(1) << shift;
      grp     = cnt >> shift;
      half_m1 = (MAX_LOG'(1) << (len_log - LOGW'(1))) - MAX_LOG'(1);
      full_m1 = (MAX_LOG'(1) << len_log) - MAX_LOG'(1);
      tw_idx  = grp[MAX_LOG-2:0];
      if (phase == PH_SCALE) begin
         lo_off = cnt;
         hi_off = cnt;
      end else begin
         lo_off = (grp << (shift + LOGW'(1))) | (cnt & (span - MAX_LOG'(1)));
         hi_off = lo_off | span;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         inv_q   <= 1'b0;
         len_log <= '0;
         stage   <= '0;
         cnt     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase   <= PH_BFLY;
                  inv_q   <= inv;
                  len_log <= log_n;
                  stage   <= '0;
                  cnt     <= '0;
               end
            end
            PH_BFLY: begin
               if (cnt == half_m1) begin
                  cnt <= '0;
                  if (stage == len_log - LOGW'(1)) begin
                     if (inv_q) begin
                        phase <= PH_SCALE;
                     end else begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                     end
                  end else begin
                     stage <= stage + LOGW'(1);
                  end
               end else begin
                  cnt <= cnt + MAX_LOG'(1);
               end
            end
            PH_SCALE: begin
               if (cnt == full_m1) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + MAX_LOG'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/gl_ntt_engine.sv
module gl_ntt_engine
   import gl_ntt_pkg::*;
#(
   parameter int ADDR_W  = 9,
   parameter int MAX_LOG = 8,
   parameter int LOGW    = $clog2(MAX_LOG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [LOGW-1:0]   cmd_log,
   input  logic              cmd_inv,
   output logic              busy,
   output logic              done,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [63:0]       host_wdata,
   output logic [63:0]       host_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (MAX_LOG < 2) begin : g_bad_log
         $error("gl_ntt_engine: MAX_LOG must be at least 2");
      end
      if (ADDR_W < MAX_LOG) begin : g_bad_addr
         $error("gl_ntt_engine: ADDR_W must cover the largest transform");
      end
      if ((1 << LOGW) <= MAX_LOG) begin : g_bad_logw
         $error("gl_ntt_engine: LOGW too narrow for MAX_LOG");
      end
   endgenerate

   logic [63:0]        mem [DEPTH];
   ntt_phase_e         phase;
   logic               inv_q;
   logic               log_ok;
   logic               start;
   logic [ADDR_W-1:0]  base_q;
   logic [63:0]        ninv_q;
   logic [MAX_LOG-1:0] lo_off;
   logic [MAX_LOG-1:0] hi_off;
   logic [MAX_LOG-2:0] tw_idx;
   logic [ADDR_W-1:0]  lo_addr;
   logic [ADDR_W-1:0]  hi_addr;
   logic [63:0]        rom_w;
   logic [63:0]        op_a;
   logic [63:0]        op_b;
   logic [63:0]        op_w;
   logic [63:0]        bf_prod;
   logic [63:0]        bf_sum;
   logic [63:0]        bf_diff;

   assign busy   = (phase != PH_IDLE);
   assign log_ok = (cmd_log != '0) && (cmd_log <= LOGW'(MAX_LOG));
   assign start  = cmd_valid && !busy && log_ok;

   gl_ntt_seq #(
      .MAX_LOG (MAX_LOG),
      .LOGW    (LOGW)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .log_n  (cmd_log),
      .inv    (cmd_inv),
      .phase  (phase),
      .inv_q  (inv_q),
      .lo_off (lo_off),
      .hi_off (hi_off),
      .tw_idx (tw_idx),
      .done   (done)
   );

   gl_twiddle_rom #(
      .MAX_LOG (MAX_LOG)
   ) u_rom (
      .inv (inv_q),
      .idx (tw_idx),
      .w   (rom_w)
   );

   // N^-1 = p - (p-1)/N because N * (p-1)/N = -1 (mod p).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ninv_q <= 64'd1;
      end else if (start) begin
         base_q <= cmd_base;
         ninv_q <= GL_P - ((GL_P - 64'd1) >> cmd_log);
      end
   end

   assign lo_addr = base_q + ADDR_W'(lo_off);
   assign hi_addr = base_q + ADDR_W'(hi_off);

   always_comb begin
      op_a = mem[lo_addr];
      if (phase == PH_SCALE) begin
         op_b = mem[lo_addr];
         op_w = ninv_q;
      end else begin
         op_b = mem[hi_addr];
         op_w = rom_w;
      end
   end

   gl_butterfly u_bfly (
      .a    (op_a),
      .b    (op_b),
      .w    (op_w),
      .prod (bf_prod),
      .sum  (bf_sum),
      .diff (bf_diff)
   );

   always_ff @(posedge clk) begin
      if (phase == PH_BFLY) begin
         mem[lo_addr] <= bf_sum;
         mem[hi_addr] <= bf_diff;
      end else if (phase == PH_SCALE) begin
         mem[lo_addr] <= bf_prod;
      end else if (host_we) begin
         mem[host_addr] <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_rdata <= '0;
      else        host_rdata <= mem[host_addr];
   end

endmodule

// File: rtl/gl_ntt_engine_chk.sv
module gl_ntt_engine_chk #(
   parameter int MAX_LOG = 8,
   parameter int LOGW    = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic [LOGW-1:0] cmd_log,
   input logic            cmd_inv,
   input logic            busy,
   input logic            done
);

   logic accept;
   logic bad_cmd;
   int   run_cnt;
   int   exp_cnt;

   assign bad_cmd = cmd_valid && ((cmd_log == '0) || (cmd_log > LOGW'(MAX_LOG)));
   assign accept  = cmd_valid && !busy && !bad_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= 0;
         exp_cnt <= 0;
      end else if (accept) begin
         run_cnt <= 0;
         exp_cnt <= ((1 << (int'(cmd_log) - 1)) * int'(cmd_log))
                  + (cmd_inv ? (1 << int'(cmd_log)) : 0);
      end else if (busy) begin
         run_cnt <= run_cnt + 1;
      end
   end

   // R4
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == exp_cnt));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R6
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   // R7
   bad_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_cmd && !busy) |=> !busy);

endmodule

bind gl_ntt_engine gl_ntt_engine_chk #(
   .MAX_LOG (MAX_LOG),
   .LOGW    (LOGW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_log   (cmd_log),
   .cmd_inv   (cmd_inv),
   .busy      (busy),
   .done      (done)
);

// File: tb/tb_gl_ntt_engine.sv
module tb_gl_ntt_engine;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int ADDR_W  = 9;
   localparam int MAX_LOG = 8;
   localparam int LOGW    = 4;
   localparam int DEPTH   = 1 << ADDR_W;
   localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [ADDR_W-1:0] cmd_base = '0;
   logic [LOGW-1:0]   cmd_log = '0;
   logic              cmd_inv = 1'b0;
   logic              busy;
   logic              done;
   logic              host_we = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [63:0]       host_wdata = '0;
   logic [63:0]       host_rdata;

   int checks = 0;
   int errors = 0;

   logic [63:0] vin  [256];
   logic [63:0] vexp [256];
   logic [63:0] vout [256];
   logic [63:0] wpow [256];
   logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

   always #5 clk = ~clk;

   gl_ntt_engine #(
      .ADDR_W  (ADDR_W),
      .MAX_LOG (MAX_LOG),
      .LOGW    (LOGW)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_base   (cmd_base),
      .cmd_log    (cmd_log),
      .cmd_inv    (cmd_inv),
      .busy       (busy),
      .done       (done),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata)
   );

   function automatic logic [63:0] fmul(input logic [63:0] a, input logic [63:0] b);
      logic [127:0] t;
      t = ({64'd0, a} * {64'd0, b}) % {64'd0, P};
      return t[63:0];
   endfunction

   function automatic logic [63:0] fadd(input logic [63:0] a, input logic [63:0] b);
      logic [64:0] t;
      t = ({1'b0, a} + {1'b0, b}) % {1'b0, P};
      return t[63:0];
   endfunction

   function automatic logic [63:0] fpow(input logic [63:0] b, input logic [63:0] e);
      logic [63:0] r;
      logic [63:0] x;
      r = 64'd1;
      x = b;
      for (int i = 0; i < 64; i++) begin
         if (e[i]) r = fmul(r, x);
         x = fmul(x, x);
      end
      return r;
   endfunction

   function automatic int brv(input int v, input int bits);
      int r;
      r = 0;
      for (int i = 0; i < bits; i++) if (v[i]) r = r | (1 << (bits - 1 - i));
      return r;
   endfunction

   function automatic logic [63:0] next_rand();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed % P;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input int addr, input logic [63:0] d);
      @(negedge clk);
      host_we    = 1'b1;
      host_addr  = ADDR_W'(addr % DEPTH);
      host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(input int addr, output logic [63:0] d);
      @(negedge clk);
      host_addr = ADDR_W'(addr % DEPTH);
      @(negedge clk);
      d = host_rdata;
   endtask

   // Direct O(N^2) transform of vin into vexp, natural order.
   task automatic direct(input int lg, input bit inv);
      int n;
      logic [63:0] w;
      logic [63:0] acc;
      n = 1 << lg;
      w = fpow(64'd7, (P - 64'd1) >> lg);
      if (inv) w = fpow(w, 64'(n - 1));
      wpow[0] = 64'd1;
      for (int t = 1; t < n; t++) wpow[t] = fmul(wpow[t-1], w);
      for (int k = 0; k < n; k++) begin
         acc = 64'd0;
         for (int j = 0; j < n; j++) acc = fadd(acc, fmul(vin[j], wpow[(j * k) % n]));
         if (inv) acc = fmul(acc, fpow(64'(n), P - 64'd2));
         vexp[k] = acc;
      end
   endtask

   task automatic load_block(input int base, input int n);
      for (int i = 0; i < n; i++) host_write(base + i, vin[i]);
   endtask

   task automatic read_block(input int base, input int n);
      for (int i = 0; i < n; i++) host_read(base + i, vout[i]);
   endtask

   // Issue a command; on the second busy cycle optionally inject a
   // competing command and/or a host write.
   task automatic run_ntt(input int base, input int lg, input bit inv,
                          input bit inj_cmd, input bit inj_we, input int inj_addr,
                          input logic [63:0] inj_data, output int cyc, output bit pulse_ok);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_base  = ADDR_W'(base % DEPTH);
      cmd_log   = LOGW'(lg);
      cmd_inv   = inv;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         if (cyc == 2) begin
            cmd_valid  = inj_cmd;
            cmd_base   = ADDR_W'(100);
            cmd_log    = LOGW'(5);
            cmd_inv    = ~inv;
            host_we    = inj_we;
            host_addr  = ADDR_W'(inj_addr % DEPTH);
            host_wdata = inj_data;
         end else begin
            cmd_valid = 1'b0;
            host_we   = 1'b0;
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      host_we   = 1'b0;
      pulse_ok  = done;
      @(negedge clk);
      if (done) pulse_ok = 1'b0;
   endtask

   function automatic int exp_cycles(input int lg, input bit inv);
      return ((1 << lg) / 2) * lg + (inv ? (1 << lg) : 0);
   endfunction

   task automatic fwd_case(input int base, input int lg, input string tag);
      int n;
      int cyc;
      bit pok;
      logic [63:0] g;
      n = 1 << lg;
      load_block(base, n);
      host_write(base - 1, 64'hA5A5_0000_0000_0001);
      host_write(base + n, 64'h5A5A_0000_0000_0002);
      run_ntt(base, lg, 1'b0, 1'b0, 1'b0, 0, 64'd0, cyc, pok);
      checks++;
      if (cyc != exp_cycles(lg, 1'b0)) begin
         errors++;
         $display("FAIL R4: busy cycles actual %0d expected %0d", cyc, exp_cycles(lg, 1'b0));
      end
      chk("R5 done pulse", 64'(pok), 64'd1);
      direct(lg, 1'b0);
      read_block(base, n);
      for (int i = 0; i < n; i++) chk(tag, vout[i], vexp[brv(i, lg)]);
      host_read(base - 1, g);
      chk("R9 guard below", g, 64'hA5A5_0000_0000_0001);
      host_read(base + n, g);
      chk("R9 guard above", g, 64'h5A5A_0000_0000_0002);
   endtask

   initial begin
      int cyc;
      bit pok;
      int n;
      logic [63:0] g;
      logic [63:0] orig [256];

      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", 64'(busy), 64'd0);
      chk("R10 done", 64'(done), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 and R3: every length, with wrapping bases for the larger ones
      for (int lg = 1; lg <= MAX_LOG; lg++) begin
         for (int i = 0; i < (1 << lg); i++) vin[i] = next_rand();
         fwd_case(37 * lg + 200, lg, "R1 forward");
      end

      // R11: extreme operands
      for (int i = 0; i < 16; i++) vin[i] = P - 64'd1;
      fwd_case(8, 4, "R11 all p-1");
      for (int i = 0; i < 16; i++) vin[i] = (i % 3 == 0) ? P - 64'd1 : 64'(i % 2);
      fwd_case(30, 4, "R11 mixed");

      // R2: inverse against direct evaluation
      for (int i = 0; i < 16; i++) vin[i] = next_rand();
      load_block(64, 16);
      run_ntt(64, 4, 1'b1, 1'b0, 1'b0, 0, 64'd0, cyc, pok);
      checks++;
      if (cyc != exp_cycles(4, 1'b1)) begin
         errors++;
         $display("FAIL R4: inverse busy cycles actual %0d expected %0d", cyc, exp_cycles(4, 1'b1));
      end
      chk("R5 done pulse inverse", 64'(pok), 64'd1);
      direct(4, 1'b1);
      read_block(64, 16);
      for (int i = 0; i < 16; i++) chk("R2 inverse", vout[i], vexp[brv(i, 4)]);

      // R2: round trips
      for (int lg = 1; lg <= MAX_LOG; lg += 3) begin
         n = 1 << lg;
         for (int i = 0; i < n; i++) begin
            orig[i] = next_rand();
            vin[i]  = orig[i];
         end
         load_block(0, n);
         run_ntt(0, lg, 1'b0, 1'b0, 1'b0, 0, 64'd0, cyc, pok);
         read_block(0, n);
         for (int i = 0; i < n; i++) vin[brv(i, lg)] = vout[i];
         load_block(0, n);
         run_ntt(0, lg, 1'b1, 1'b0, 1'b0, 0, 64'd0, cyc, pok);
         read_block(0, n);
         for (int i = 0; i < n; i++) chk("R2 round trip", vout[i], orig[brv(i, lg)]);
      end

      // R6 and R8: competing command and host write during a run
      host_write(100, 64'hDEAD_0000_0000_0100);
      for (int i = 0; i < 8; i++) vin[i] = next_rand();
      load_block(0, 8);
      host_write(8, 64'hBEEF_0000_0000_0008);
      run_ntt(0, 3, 1'b0, 1'b1, 1'b1, 8, 64'h1111_0000_0000_0000, cyc, pok);
      checks++;
      if (cyc != exp_cycles(3, 1'b0)) begin
         errors++;
         $display("FAIL R6: busy cycles actual %0d expected %0d", cyc, exp_cycles(3, 1'b0));
      end
      direct(3, 1'b0);
      read_block(0, 8);
      for (int i = 0; i < 8; i++) chk("R6 result kept", vout[i], vexp[brv(i, 3)]);
      host_read(100, g);
      chk("R6 other block untouched", g, 64'hDEAD_0000_0000_0100);
      host_read(8, g);
      chk("R8 write while busy ignored", g, 64'hBEEF_0000_0000_0008);

      // R7: illegal lengths are ignored
      host_write(300, 64'd77);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_base  = ADDR_W'(300);
         cmd_log   = (k == 0) ? LOGW'(0) : LOGW'(MAX_LOG + 1);
         cmd_inv   = 1'b0;
         @(negedge clk);
         cmd_valid = 1'b0;
         chk("R7 busy stays low", 64'(busy), 64'd0);
         @(negedge clk);
         chk("R7 no done", 64'(done), 64'd0);
      end
      host_read(300, g);
      chk("R7 data unchanged", g, 64'd77);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(10 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule